// File: doc/BRIEF.md
# Pipelined Floating-Point Multiplier with Tagged Special Values

This block multiplies two numbers held in a compact floating-point word. The top two bits of the word form a class tag that alone marks zero, infinity and NaN. The exponent and fraction fields carry meaning only when the tag says the value is an ordinary number. Reserved exponent codes and subnormals are not used. Width parameters set the exponent and fraction sizes. The word is `EXP_W + FRAC_W + 3` bits wide.

The unit accepts one operand pair on any cycle on which `in_valid` is high. The paired result appears a fixed six cycles later, flagged by `out_valid`. Inside, the unit multiplies the significands with their hidden ones and adds the exponents less the bias. It renormalises by at most one place, rounds to nearest with ties to even, checks the final exponent range and then settles the class tag. Stage-to-stage events (normalisation shift, rounding carry, range overflow and underflow) are exposed as named signals for the bound checker.

Top module: `flt_mult`

## Requirements
- R1: A word is laid out from its most significant bit as class tag (2 bits), sign (1 bit), biased exponent (`EXP_W` bits) and fraction (`FRAC_W` bits). The exponent bias is 2^(EXP_W-1)-1, so 1.0 is tag 01, exponent 127 and fraction 0 when EXP_W=8.
- R2: The class tag is encoded as 00 zero, 01 ordinary number, 10 infinity and 11 NaN.
- R3: The result sign bit is the XOR of the two operand sign bits, for every result class.
- R4: For two ordinary operands, the exact product of the significands 1.fa and 1.fb is formed. If that product is at least 2, it is shifted right one place and the exponent is raised by one. The result exponent is ea + eb − bias plus that shift.
- R5: The fraction is rounded to nearest. An exact halfway case rounds to the value whose fraction LSB is 0.
- R6: If rounding carries out of an all-ones fraction, the fraction becomes 0 and the exponent rises by one more.
- R7: An ordinary product whose final biased exponent is 2^EXP_W−1 or larger becomes infinity (tag 10). A final exponent of 2^EXP_W−2 stays an ordinary number.
- R8: An ordinary product whose final biased exponent is 0 or below becomes zero (tag 00) with the XOR sign kept. A final exponent of 1 stays an ordinary number.
- R9: The result is NaN (tag 11) when either operand is NaN, or when one operand is zero and the other is infinity.
- R10: Infinity times infinity or times an ordinary number gives infinity. Zero times zero or times an ordinary number gives zero. The exponent and fraction fields of zero, infinity and NaN operands have no effect on the result. Every non-ordinary result carries all-zero exponent and fraction fields.
- R11: `out_valid` rises exactly 6 clock cycles after each accepted `in_valid`, carrying that pair's result, and stays low in every other cycle. Operands may arrive back to back. Reset clears all valid state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | EXP_W+FRAC_W+3 | First operand word |
| in_b | input | EXP_W+FRAC_W+3 | Second operand word |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | EXP_W+FRAC_W+3 | Product word |

## Verification
The bench builds the unit with an 8-bit exponent and a 23-bit fraction. This makes the exact 48-bit significand product fit in a 64-bit integer, so the bench model can round by remainder comparison instead of guard and sticky bits. With this width, random exponent picks clustered near 63 and 190 land the final exponent on both range edges (0/1 and 254/255). A short search over fractions paired with a near-reciprocal partner reliably produces the rounding carry. Ties are reached with hand-chosen fractions whose product ends exactly on a half unit.

// File: rtl/flt_mult_pkg.sv
package flt_mult_pkg;

  typedef enum logic [1:0] {
    TAG_ZERO = 2'b00,
    TAG_NORM = 2'b01,
    TAG_INF  = 2'b10,
    TAG_NAN  = 2'b11
  } fm_tag_e;

  // Class of the product decided from the operand classes alone.
  function automatic fm_tag_e tag_combine(fm_tag_e ta, fm_tag_e tb);
    if (ta == TAG_NAN || tb == TAG_NAN) return TAG_NAN;
    if ((ta == TAG_ZERO && tb == TAG_INF) || (ta == TAG_INF && tb == TAG_ZERO)) return TAG_NAN;
    if (ta == TAG_INF || tb == TAG_INF) return TAG_INF;
    if (ta == TAG_ZERO || tb == TAG_ZERO) return TAG_ZERO;
    return TAG_NORM;
  endfunction

  // Nearest-even increment decision.
  function automatic logic rne_up(logic lsb, logic guard, logic sticky);
    return guard & (sticky | lsb);
  endfunction

endpackage

// File: rtl/flt_mult_vpipe.sv
module flt_mult_vpipe #(
  parameter int LAT = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vin,
  output logic [LAT-1:0] vstg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vstg <= '0;
    else        vstg <= {vstg[LAT-2:0], vin};
  end

endmodule

// File: rtl/flt_mult_sigmul.sv
module flt_mult_sigmul
  import flt_mult_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MW = FRAC_W + 1,
  localparam int PW = 2 * MW,
  localparam int XW = EXP_W + 2
) (
  input  logic                 clk,
  input  fm_tag_e              a_tag,
  input  fm_tag_e              b_tag,
  input  logic                 a_sgn,
  input  logic                 b_sgn,
  input  logic [EXP_W-1:0]     a_exp,
  input  logic [EXP_W-1:0]     b_exp,
  input  logic [FRAC_W-1:0]    a_frac,
  input  logic [FRAC_W-1:0]    b_frac,
  output logic [PW-1:0]        prod,
  output logic signed [XW-1:0] esum,
  output logic                 sgn,
  output fm_tag_e              cls
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [PW-1:0]        prod_c;
  logic signed [XW-1:0] esum_c;

  always_comb begin
    prod_c = PW'({1'b1, a_frac}) * PW'({1'b1, b_frac});
    esum_c = XW'(a_exp) + XW'(b_exp) - XW'(BIAS);
  end

  always_ff @(posedge clk) begin
    prod <= prod_c;
    esum <= esum_c;
    sgn  <= a_sgn ^ b_sgn;
    cls  <= tag_combine(a_tag, b_tag);
  end

endmodule

// File: rtl/flt_mult_normrnd.sv
module flt_mult_normrnd
  import flt_mult_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int MW = FRAC_W + 1,
  localparam int PW = 2 * MW,
  localparam int XW = EXP_W + 2
) (
  input  logic                 clk,
  input  logic [PW-1:0]        prod,
  input  logic signed [XW-1:0] esum,
  input  logic                 sgn_i,
  input  fm_tag_e              cls_i,
  output logic [FRAC_W-1:0]    frac_o,
  output logic signed [XW-1:0] exp_o,
  output logic                 sgn_o,
  output fm_tag_e              cls_o,
  output logic                 norm_evt,
  output logic                 rcarry_evt
);

  // Stage 3: one-place normalisation with guard and sticky extraction
  logic                 top_c;
  logic [FRAC_W-1:0]    fr_c;
  logic                 g_c, st_c;
  logic signed [XW-1:0] e3_c;

  always_comb begin
    top_c = prod[PW-1];
    if (top_c) begin
      fr_c = prod[2*FRAC_W : FRAC_W+1];
      g_c  = prod[FRAC_W];
      st_c = |prod[FRAC_W-1:0];
    end else begin
      fr_c = prod[2*FRAC_W-1 : FRAC_W];
      g_c  = prod[FRAC_W-1];
      st_c = |prod[FRAC_W-2:0];
    end
    e3_c = esum + XW'(top_c);
  end

  logic [FRAC_W-1:0]    fr3;
  logic                 g3, st3, sgn3;
  logic signed [XW-1:0] e3;
  fm_tag_e              cls3;

  always_ff @(posedge clk) begin
    fr3      <= fr_c;
    g3       <= g_c;
    st3      <= st_c;
    e3       <= e3_c;
    sgn3     <= sgn_i;
    cls3     <= cls_i;
    norm_evt <= top_c;
  end

  // Stage 4: rounding increment and carry into the exponent
  logic                 up_c, cy_c;
  logic [FRAC_W-1:0]    fr4_c;
  logic signed [XW-1:0] e4_c;

  always_comb begin
    up_c          = rne_up(fr3[0], g3, st3);
    {cy_c, fr4_c} = {1'b0, fr3} + (FRAC_W + 1)'(up_c);
    e4_c          = e3 + XW'(cy_c);
  end

  always_ff @(posedge clk) begin
    frac_o     <= fr4_c;
    exp_o      <= e4_c;
    sgn_o      <= sgn3;
    cls_o      <= cls3;
    rcarry_evt <= cy_c;
  end

endmodule

// File: rtl/flt_mult_pack.sv
module flt_mult_pack
  import flt_mult_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int XW = EXP_W + 2,
  localparam int WORD_W = EXP_W + FRAC_W + 3
) (
  input  logic                 clk,
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic signed [XW-1:0] exp_i,
  input  logic                 sgn_i,
  input  fm_tag_e              cls_i,
  output logic                 ovf_evt,
  output logic                 unf_evt,
  output logic                 is_norm,
  output logic [WORD_W-1:0]    res
);

  localparam logic signed [XW-1:0] EXP_TOP = XW'((1 << EXP_W) - 1);

  // Stage 5: range classification
  logic [FRAC_W-1:0] fr5;
  logic [EXP_W-1:0]  e5;
  logic              sgn5;

  always_ff @(posedge clk) begin
    ovf_evt <= (exp_i >= EXP_TOP);
    unf_evt <= (exp_i <= 0);
    is_norm <= (cls_i == TAG_NORM);
    fr5     <= frac_i;
    e5      <= exp_i[EXP_W-1:0];
    sgn5    <= sgn_i;
  end

  logic [1:0] cls5;
  always_ff @(posedge clk) cls5 <= cls_i;

  // Stage 6: final class and packing
  fm_tag_e tag_c;
  always_comb begin
    tag_c = fm_tag_e'(cls5);
    if (is_norm) begin
      if (ovf_evt)      tag_c = TAG_INF;
      else if (unf_evt) tag_c = TAG_ZERO;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_c == TAG_NORM) res <= {tag_c, sgn5, e5, fr5};
    else                   res <= {tag_c, sgn5, {(EXP_W + FRAC_W){1'b0}}};
  end

endmodule

// File: rtl/flt_mult.sv
module flt_mult
  import flt_mult_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = EXP_W + FRAC_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_res
);

  localparam int LAT = 6;
  localparam int MW  = FRAC_W + 1;
  localparam int PW  = 2 * MW;
  localparam int XW  = EXP_W + 2;

  // Valid tracking
  logic [LAT-1:0] vstg;
  flt_mult_vpipe #(.LAT(LAT)) i_vpipe (
    .clk(clk), .rst_n(rst_n), .vin(in_valid), .vstg(vstg)
  );
  assign out_valid = vstg[LAT-1];

  // Stage 1: operand capture
  logic [WORD_W-1:0] a_q, b_q;
  always_ff @(posedge clk) begin
    a_q <= in_a;
    b_q <= in_b;
  end

  // Stage 2
  logic [PW-1:0]        s2_prod;
  logic signed [XW-1:0] s2_esum;
  logic                 s2_sgn;
  fm_tag_e              s2_cls;

  flt_mult_sigmul #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_sigmul (
    .clk    (clk),
    .a_tag  (fm_tag_e'(a_q[WORD_W-1 -: 2])),
    .b_tag  (fm_tag_e'(b_q[WORD_W-1 -: 2])),
    .a_sgn  (a_q[WORD_W-3]),
    .b_sgn  (b_q[WORD_W-3]),
    .a_exp  (a_q[FRAC_W +: EXP_W]),
    .b_exp  (b_q[FRAC_W +: EXP_W]),
    .a_frac (a_q[FRAC_W-1:0]),
    .b_frac (b_q[FRAC_W-1:0]),
    .prod   (s2_prod),
    .esum   (s2_esum),
    .sgn    (s2_sgn),
    .cls    (s2_cls)
  );

  // Stages 3 and 4
  logic [FRAC_W-1:0]    s4_frac;
  logic signed [XW-1:0] s4_exp;
  logic                 s4_sgn;
  fm_tag_e              s4_cls;
  logic                 norm_evt, rcarry_evt;

  flt_mult_normrnd #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_normrnd (
    .clk        (clk),
    .prod       (s2_prod),
    .esum       (s2_esum),
    .sgn_i      (s2_sgn),
    .cls_i      (s2_cls),
    .frac_o     (s4_frac),
    .exp_o      (s4_exp),
    .sgn_o      (s4_sgn),
    .cls_o      (s4_cls),
    .norm_evt   (norm_evt),
    .rcarry_evt (rcarry_evt)
  );

  // Stages 5 and 6
  logic s5_ovf, s5_unf, s5_norm, s5_vld;
  assign s5_vld = vstg[LAT-2];

  flt_mult_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_pack (
    .clk     (clk),
    .frac_i  (s4_frac),
    .exp_i   (s4_exp),
    .sgn_i   (s4_sgn),
    .cls_i   (s4_cls),
    .ovf_evt (s5_ovf),
    .unf_evt (s5_unf),
    .is_norm (s5_norm),
    .res     (out_res)
  );

endmodule

// File: rtl/flt_mult_chk.sv
module flt_mult_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = EXP_W + FRAC_W + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_a,
  input logic [WORD_W-1:0] in_b,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_res,
  input logic              s5_vld,
  input logic              s5_norm,
  input logic              s5_ovf,
  input logic              s5_unf
);

  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  // R11: fixed six-cycle valid latency
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd6) |-> (out_valid == $past(in_valid, 6)));

  // R3: sign is XOR of operand signs
  a_r3_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd6 && $past(in_valid, 6)) |->
      (out_res[WORD_W-3] == ($past(in_a[WORD_W-3], 6) ^ $past(in_b[WORD_W-3], 6))));

  // R9: a NaN operand forces a NaN result
  a_r9_nan_prop: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 3'd6 && $past(in_valid, 6) &&
     ($past(in_a[WORD_W-1 -: 2], 6) == 2'b11 || $past(in_b[WORD_W-1 -: 2], 6) == 2'b11)) |->
      (out_res[WORD_W-1 -: 2] == 2'b11));

  // R10: special results carry clean fields
  a_r10_special_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_res[WORD_W-1 -: 2] != 2'b01) |-> (out_res[WORD_W-4:0] == '0));

  // R7: range overflow of an ordinary product gives infinity
  a_r7_ovf_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (s5_vld && s5_norm && s5_ovf) |=> (out_res[WORD_W-1 -: 2] == 2'b10));

  // R8: range underflow of an ordinary product gives zero
  a_r8_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (s5_vld && s5_norm && s5_unf) |=> (out_res[WORD_W-1 -: 2] == 2'b00));

endmodule

bind flt_mult flt_mult_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .out_valid(out_valid), .out_res(out_res), .s5_vld(s5_vld),
  .s5_norm(s5_norm), .s5_ovf(s5_ovf), .s5_unf(s5_unf)
);

// File: tb/test_flt_mult.sv
module test_flt_mult;

  localparam int EW = 8;
  localparam int FW = 23;
  localparam int W  = EW + FW + 3;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_a, in_b;
  logic         out_valid;
  logic [W-1:0] out_res;

  flt_mult #(.EXP_W(EW), .FRAC_W(FW)) i_flt_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_res(out_res)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int pcnt     = 0;
  bit finished = 0;

  logic [W-1:0] exp_q[$];
  int           cyc_q[$];
  string        req_q[$];

  always @(posedge clk) pcnt++;

  function automatic logic [W-1:0] mk(logic [1:0] t, logic s, int e, int f);
    return {t, s, EW'(e), FW'(f)};
  endfunction

  // Reference model: exact product, remainder-based nearest-even rounding.
  function automatic logic [W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, output bit carried);
    logic [1:0] ta, tb;
    logic s;
    longint unsigned ma, mb, p, q, r, half;
    int sh, drop, e;
    carried = 0;
    ta = a[W-1 -: 2];
    tb = b[W-1 -: 2];
    s  = a[W-3] ^ b[W-3];
    if (ta == 2'b11 || tb == 2'b11 || (ta == 2'b00 && tb == 2'b10) || (ta == 2'b10 && tb == 2'b00))
      return mk(2'b11, s, 0, 0);
    if (ta == 2'b10 || tb == 2'b10) return mk(2'b10, s, 0, 0);
    if (ta == 2'b00 || tb == 2'b00) return mk(2'b00, s, 0, 0);
    ma = (64'd1 << FW) | longint'(a[FW-1:0]);
    mb = (64'd1 << FW) | longint'(b[FW-1:0]);
    p  = ma * mb;
    sh = int'((p >> (2 * FW + 1)) & 64'd1);
    drop = FW + sh;
    q = p >> drop;
    r = p - (q << drop);
    half = 64'd1 << (drop - 1);
    if (r > half || (r == half && q[0])) q++;
    e = int'(a[FW +: EW]) + int'(b[FW +: EW]) - BIAS + sh;
    if (q == (64'd1 << (FW + 1))) begin
      q = q >> 1;
      e++;
      carried = 1;
    end
    if (e >= (1 << EW) - 1) return mk(2'b10, s, 0, 0);
    if (e <= 0) return mk(2'b00, s, 0, 0);
    return mk(2'b01, s, e, int'(q[FW-1:0]));
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic chk_int(string req, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic issue_exp(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] expv, string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    exp_q.push_back(expv);
    cyc_q.push_back(pcnt);
    req_q.push_back(req);
  endtask

  task automatic issue(logic [W-1:0] a, logic [W-1:0] b);
    bit c;
    logic [W-1:0] e;
    string req;
    e = ref_mul(a, b, c);
    if (e[W-1 -: 2] == 2'b11) req = "R9";
    else if (a[W-1 -: 2] != 2'b01 || b[W-1 -: 2] != 2'b01) req = "R10";
    else if (e[W-1 -: 2] == 2'b10) req = "R7";
    else if (e[W-1 -: 2] == 2'b00) req = "R8";
    else if (c) req = "R6";
    else req = "R5";
    issue_exp(a, b, e, req);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [W-1:0] gen_op();
    logic [1:0] t;
    int e, m;
    t = ($urandom % 10 < 7) ? 2'b01 : 2'($urandom % 4);
    m = $urandom % 3;
    if (m == 0)      e = $urandom % (1 << EW);
    else if (m == 1) e = BIAS - 20 + $urandom % 41;
    else             e = (($urandom % 2) != 0) ? 62 + $urandom % 4 : 189 + $urandom % 4;
    return mk(t, 1'($urandom % 2), e, int'($urandom % (1 << FW)));
  endfunction

  // Monitor: compare each result and its latency
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1 && !finished) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R11: actual out_valid 1 expected 0 (no pending operation)");
      end else begin
        chk(req_q.pop_front(), out_res, exp_q.pop_front());
        chk_int("R11 latency", pcnt - cyc_q.pop_front(), 6);
      end
    end
  end

  task automatic finish_tb();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_tb();
  end

  initial begin
    bit c;
    logic [W-1:0] xa, xb;
    void'($urandom(32'd20240517));
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_a = '0;
    in_b = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset", {{(W-1){1'b0}}, out_valid}, '0);
    rst_n = 1'b1;
    idle();

    // Directed corner cases
    issue_exp(mk(1, 0, 127, 0), mk(1, 0, 127, 0), mk(1, 0, 127, 0), "R1 one times one");
    issue_exp(mk(1, 1, 127, 'h400000), mk(1, 0, 128, 0), mk(1, 1, 128, 'h400000), "R3 sign");
    issue_exp(mk(1, 0, 127, 'h400000), mk(1, 0, 127, 'h400000), mk(1, 0, 128, 'h100000), "R4 normalise");
    issue_exp(mk(1, 0, 127, 1), mk(1, 0, 127, 'h400000), mk(1, 0, 127, 'h400002), "R5 tie up");
    issue_exp(mk(1, 0, 127, 3), mk(1, 0, 127, 'h400000), mk(1, 0, 127, 'h400004), "R5 tie even");
    issue_exp(mk(1, 0, 254, 0), mk(1, 0, 128, 0), mk(2, 0, 0, 0), "R7 overflow");
    issue_exp(mk(1, 0, 254, 0), mk(1, 0, 127, 0), mk(1, 0, 254, 0), "R7 top edge");
    issue_exp(mk(1, 1, 1, 0), mk(1, 0, 126, 0), mk(0, 1, 0, 0), "R8 underflow");
    issue_exp(mk(1, 0, 1, 0), mk(1, 0, 127, 0), mk(1, 0, 1, 0), "R8 bottom edge");
    issue_exp(mk(1, 0, 1, 'h400000), mk(1, 0, 126, 'h400000), mk(1, 0, 1, 'h100000), "R8 lifted by shift");
    issue_exp(mk(0, 0, 5, 7), mk(2, 1, 9, 9), mk(3, 1, 0, 0), "R9 zero times inf");
    issue_exp(mk(3, 0, 77, 1), mk(0, 0, 0, 0), mk(3, 0, 0, 0), "R9 nan times zero");
    issue_exp(mk(2, 0, 33, 44), mk(1, 1, 127, 0), mk(2, 1, 0, 0), "R10 inf times normal");
    issue_exp(mk(0, 1, 200, 5), mk(1, 1, 3, 3), mk(0, 0, 0, 0), "R10 zero fields ignored");
    issue_exp(mk(2, 1, 255, 'h7fffff), mk(2, 1, 1, 1), mk(2, 0, 0, 0), "R2 inf times inf");
    issue_exp(mk(1, 0, 130, 0), mk(1, 1, 120, 0), mk(1, 1, 123, 0), "R2 normal tag");
    idle();

    // Rounding carry search: partner chosen as near-reciprocal
    for (int k = 0; k < 64; k++) begin
      longint unsigned mx, my;
      mx = (64'd1 << FW) | longint'($urandom % (1 << FW));
      my = ((64'd1 << (2 * FW + 1)) - 1) / mx;
      if (my >= (64'd1 << (FW + 1))) continue;
      if (my < (64'd1 << FW)) continue;
      xa = mk(1, 0, 127, int'(mx[FW-1:0]));
      xb = mk(1, 1, 100, int'(my[FW-1:0]));
      void'(ref_mul(xa, xb, c));
      if (c) issue(xa, xb);
    end
    idle();

    // Constrained random stream with gaps
    for (int k = 0; k < 1500; k++) begin
      if ($urandom % 4 == 0) idle();
      issue(gen_op(), gen_op());
    end
    idle();

    repeat (12) @(negedge clk);
    chk_int("R11 drained", exp_q.size(), 0);
    finish_tb();
  end

endmodule